// File: doc/BRIEF.md
# Edge-Triggered Event Counter with Snapshot

This block counts edges on an external event input in a 16-bit counter and shows that count to software through a small byte-wide register port. A control register picks the edge that counts and holds a load-enable bit that pauses counting so software can preset the count. It also has a self-clearing capture bit that freezes a coherent copy of the count for reading, and a polled mode. In polled mode the input is looked at only once per long interval of a slow timebase, which cuts activity for inputs that change slowly.

The input passes through a synchronizer before edge detection. In polled mode, each sample is compared against the previous sample. Reads of the counter bytes always return the captured copy and never the live counter, so a read cannot see a half-updated value. A stored retention-select bit has no effect inside the block.

Top module: `evt_cntr`

## Requirements
- R1: After reset the control register (address 0) and both count bytes (addresses 1 and 2) read 0x00.
- R2: With control bit 0 (edge select) at 0, each falling edge of `evt_in` adds one to the counter.
- R3: With control bit 0 at 1, each rising edge of `evt_in` adds one to the counter, and falling edges do not.
- R4: Writing control with bit 3 (capture) set copies the counter into a holding register. Address 1 reads the holding register's low byte and address 2 its high byte. Later edges do not change what is read until the next capture. Bit 3 always reads back 0.
- R5: While control bit 2 (load enable) is 1, edges are ignored, and writes to address 1 or 2 replace the low or high counter byte. Counting resumes once bit 2 is written back to 0.
- R6: Writes to address 1 or 2 while bit 2 is 0 leave the counter unchanged.
- R7: The counter wraps from 0xFFFF to 0x0000 on the next counted edge.
- R8: With control bit 1 (polled) set, the input is sampled only on the `POLL_DIV`-th `tick_32k` pulse of each period. A count occurs only when a sample is 1 and the previous sample was 0. A pulse that falls between two samples is not counted.
- R9: Writing control with bit 1 set stores bit 0 as 1 and bit 7 as 0, whatever values were written to those bits.
- R10: While `osc_on` is 0, no polled samples are taken and the count does not change in polled mode.
- R11: Control bit 7 (retention select) is stored and read back when polled mode is off.
- R12: Each edge adds exactly one, seen after a two-flop synchronizer, however long the input stays at its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 count low byte, 2 count high byte |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| evt_in | input | 1 | Asynchronous event input |
| tick_32k | input | 1 | One-cycle pulse per timebase tick |
| osc_on | input | 1 | Timebase oscillator running |

## Verification
The assertions assume that `tick_32k` is a single-cycle pulse and that `evt_in` holds each level for at least the synchronizer depth plus one cycle. Without that, an edge could merge with the next one in the synchronizer. The bench drives `evt_in` at a negative edge and holds each level for four or more cycles. For polled stimulus it holds each level across several sample periods, and it stops the tick stream while placing a glitch between samples. Writes land one per cycle, so a control write and a count-byte write never fall in the same cycle.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
   // control register bit positions
   localparam int CB_RISE = 0;
   localparam int CB_POLL = 1;
   localparam int CB_LOAD = 2;
   localparam int CB_SNAP = 3;
   localparam int CB_KEEP = 7;
   localparam int ADDR_CTRL = 0;

   typedef struct packed {
      logic keep;
      logic load_en;
      logic poll;
      logic rise;
   } evc_ctrl_t;
endpackage

// File: rtl/evcnt_sync.sv
module evcnt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("evcnt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/evcnt_poll_timer.sv
module evcnt_poll_timer #(
   parameter int POLL_DIV = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic osc_on,
   output logic stb
);
   localparam int TW = (POLL_DIV > 2) ? $clog2(POLL_DIV) : 1;
   localparam bit IS_POW2 = (POLL_DIV & (POLL_DIV - 1)) == 0;

   if (POLL_DIV < 2) begin : g_bad_div
      $error("evcnt_poll_timer: POLL_DIV must be at least 2");
   end

   logic [TW-1:0] tcnt_q;
   logic          adv;
   logic          last;

   assign adv = tick & osc_on;

   if (IS_POW2) begin : g_wrap
      // counter width matches the period, natural wrap ends it
      assign last = &tcnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   tcnt_q <= '0;
         else if (adv) tcnt_q <= tcnt_q + 1'b1;
      end
   end else begin : g_cmp
      localparam logic [TW-1:0] TOP = TW'(POLL_DIV - 1);
      assign last = (tcnt_q == TOP);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       tcnt_q <= '0;
         else if (adv) begin
            if (last) tcnt_q <= '0;
            else      tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   assign stb = adv & last;

   // R10
   osc_off_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_on |-> !stb);
   // R8
   sample_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> tick);
endmodule

// File: rtl/evcnt_edge.sv
module evcnt_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic poll,
   input  logic rise_sel,
   input  logic stb,
   output logic evt
);
   logic prev_q;
   logic cont_evt;
   logic poll_evt;

   // previous level: every cycle when continuous, per sample when polled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                prev_q <= 1'b0;
      else if (!poll || stb)     prev_q <= lvl;
   end

   assign cont_evt = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);
   assign poll_evt = stb & lvl & ~prev_q;
   assign evt      = poll ? poll_evt : cont_evt;

   // R12
   one_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt && !poll |=> !evt);
   // R8
   poll_only_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll && !stb |-> !evt);
endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
   parameter int BYTES = 2,
   parameter int DW    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt,
   input  logic                load_en,
   input  logic [BYTES-1:0]    byte_wr,
   input  logic [DW-1:0]       wdata,
   input  logic                snap_req,
   output logic [BYTES*DW-1:0] cnt_q,
   output logic [BYTES*DW-1:0] snap_q
);
   localparam int CW = BYTES * DW;
   localparam logic [CW-1:0] ONE = CW'(1);

   if (BYTES < 1) begin : g_bad_bytes
      $error("evcnt_core: BYTES must be at least 1");
   end

   logic [CW-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (load_en) begin
         for (int i = 0; i < BYTES; i++) begin
            if (byte_wr[i]) cnt_d[i*DW +: DW] = wdata;
         end
      end else if (evt) begin
         cnt_d = cnt_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         snap_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (snap_req) snap_q <= cnt_q;
      end
   end

   // R5
   held_while_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && !(|byte_wr) |=> $stable(cnt_q));
   // R6
   idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en && !evt |=> $stable(cnt_q));
   // R7
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en && evt |=> cnt_q == ($past(cnt_q) + ONE));
   // R4
   capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> snap_q == $past(cnt_q));
   // R4
   capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> $stable(snap_q));
endmodule

// File: rtl/evt_cntr.sv
module evt_cntr
   import evcnt_pkg::*;
#(
   parameter int CNT_BYTES   = 2,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int POLL_DIV    = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              evt_in,
   input  logic              tick_32k,
   input  logic              osc_on
);
   localparam int CW = CNT_BYTES * DATA_W;

   if (DATA_W < 8) begin : g_bad_dw
      $error("evt_cntr: DATA_W must be at least 8");
   end
   if ((1 << ADDR_W) < CNT_BYTES + 1) begin : g_bad_aw
      $error("evt_cntr: ADDR_W too small for the register map");
   end

   evc_ctrl_t            ctrl_q;
   logic                 ctrl_wr;
   logic                 snap_req;
   logic [CNT_BYTES-1:0] byte_wr;
   logic                 lvl;
   logic                 stb;
   logic                 evt;
   logic [CW-1:0]        cnt_q;
   logic [CW-1:0]        snap_q;

   assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
   assign snap_req = ctrl_wr && bus_wdata[CB_SNAP];

   for (genvar b = 0; b < CNT_BYTES; b++) begin : g_bsel
      assign byte_wr[b] = bus_wr && (bus_addr == ADDR_W'(b + 1));
   end

   // control register; polled mode overrides edge and retention bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q.poll    <= bus_wdata[CB_POLL];
         ctrl_q.rise    <= bus_wdata[CB_RISE] | bus_wdata[CB_POLL];
         ctrl_q.keep    <= bus_wdata[CB_KEEP] & ~bus_wdata[CB_POLL];
         ctrl_q.load_en <= bus_wdata[CB_LOAD];
      end
   end

   evcnt_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (evt_in),
      .dout (lvl)
   );

   evcnt_poll_timer #(.POLL_DIV(POLL_DIV)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_32k),
      .osc_on(osc_on),
      .stb   (stb)
   );

   evcnt_edge i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl),
      .poll    (ctrl_q.poll),
      .rise_sel(ctrl_q.rise),
      .stb     (stb),
      .evt     (evt)
   );

   evcnt_core #(.BYTES(CNT_BYTES), .DW(DATA_W)) i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .load_en (ctrl_q.load_en),
      .byte_wr (byte_wr),
      .wdata   (bus_wdata),
      .snap_req(snap_req),
      .cnt_q   (cnt_q),
      .snap_q  (snap_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
         bus_rdata[CB_RISE] = ctrl_q.rise;
         bus_rdata[CB_POLL] = ctrl_q.poll;
         bus_rdata[CB_LOAD] = ctrl_q.load_en;
         bus_rdata[CB_KEEP] = ctrl_q.keep;
      end
      for (int b = 0; b < CNT_BYTES; b++) begin
         if (bus_addr == ADDR_W'(b + 1)) bus_rdata = snap_q[b*DATA_W +: DATA_W];
      end
   end

   // R9
   poll_forces_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.poll |-> ctrl_q.rise && !ctrl_q.keep);
   // R4
   capture_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ADDR_CTRL)) |-> !bus_rdata[CB_SNAP]);
endmodule

// File: tb/test_evt_cntr.sv
module test_evt_cntr;
   localparam int DIV = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       evt_in = 1'b0;
   logic       tick_run = 1'b0;
   logic       osc_on = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] cur_ctrl = 8'h00;

   always #2.5 clk = ~clk;

   evt_cntr #(.POLL_DIV(DIV)) i_evt_cntr (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .evt_in   (evt_in),
      .tick_32k (tick_run),
      .osc_on   (osc_on)
   );

   // rows: control value, start level, toggle count, running expected count
   typedef struct packed {
      logic [7:0]  ctrl;
      logic        start;
      logic [3:0]  toggles;
      logic [15:0] total;
   } row_t;
   localparam row_t TBL [6] = '{
      '{8'h00, 1'b0, 4'd4, 16'd2},
      '{8'h01, 1'b0, 4'd4, 16'd4},
      '{8'h01, 1'b1, 4'd3, 16'd5},
      '{8'h00, 1'b1, 4'd3, 16'd7},
      '{8'h80, 1'b0, 4'd6, 16'd10},
      '{8'h81, 1'b1, 4'd5, 16'd12}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_ctrl(input logic [7:0] v);
      cur_ctrl = v;
      wr(2'd0, v);
   endtask

   task automatic get_cnt(output logic [15:0] v);
      logic [7:0] lo, hi;
      wr(2'd0, cur_ctrl | 8'h08);
      rd(2'd1, lo);
      rd(2'd2, hi);
      v = {hi, lo};
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic toggle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         evt_in = ~evt_in;
         idle(4);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      logic [15:0] base;
      logic [7:0]  r;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(2'd0, r); chk("R1 ctrl", {8'h00, r}, 16'h0000);
      rd(2'd1, r); chk("R1 low", {8'h00, r}, 16'h0000);
      rd(2'd2, r); chk("R1 high", {8'h00, r}, 16'h0000);

      // R2 R3 R11 R12 vector table
      for (int i = 0; i < 6; i++) begin
         set_ctrl(8'h04);
         evt_in = TBL[i].start;
         idle(6);
         set_ctrl(TBL[i].ctrl);
         toggle(int'(TBL[i].toggles));
         idle(4);
         get_cnt(v);
         chk($sformatf("R2/R3/R12 row %0d", i), v, TBL[i].total);
      end

      // R11 retention bit stored
      set_ctrl(8'h80);
      rd(2'd0, r); chk("R11 readback", {8'h00, r}, 16'h0080);

      // R4 capture holds; capture bit reads 0
      set_ctrl(8'h01);
      evt_in = 1'b0; idle(6);
      get_cnt(base);
      toggle(2);
      idle(4);
      rd(2'd1, r); chk("R4 held low", {8'h00, r}, {8'h00, base[7:0]});
      rd(2'd0, r); chk("R4 bit3 zero", {8'h00, r}, 16'h0001);
      get_cnt(v); chk("R4 new capture", v, base + 16'd1);
      base = v;

      // R6 writes ignored without load enable
      wr(2'd1, 8'h55);
      wr(2'd2, 8'hAA);
      get_cnt(v); chk("R6 ignored", v, base);

      // R5 load while edges are blocked
      set_ctrl(8'h05);
      toggle(4);
      wr(2'd1, 8'hFE);
      wr(2'd2, 8'hFF);
      toggle(2);
      idle(4);
      get_cnt(v); chk("R5 loaded", v, 16'hFFFE);

      // R7 wrap
      set_ctrl(8'h01);
      toggle(2);
      idle(4);
      get_cnt(v); chk("R5 resume", v, 16'hFFFF);
      toggle(2);
      idle(4);
      get_cnt(v); chk("R7 wrap", v, 16'h0000);

      // R9 polled mode forces bits
      evt_in = 1'b0;
      idle(6);
      set_ctrl(8'h82);
      rd(2'd0, r); chk("R9 forced", {8'h00, r}, 16'h0003);
      get_cnt(base);

      // R8 glitch between samples missed
      tick_run = 1'b0;
      @(negedge clk); evt_in = 1'b1; idle(4);
      evt_in = 1'b0; idle(4);
      tick_run = 1'b1; idle(3 * DIV);
      get_cnt(v); chk("R8 glitch missed", v, base);
      evt_in = 1'b1; idle(3 * DIV);
      get_cnt(v); chk("R8 sampled rise", v, base + 16'd1);
      idle(3 * DIV);
      get_cnt(v); chk("R8 held level", v, base + 16'd1);
      evt_in = 1'b0; idle(3 * DIV);
      evt_in = 1'b1; idle(3 * DIV);
      get_cnt(v); chk("R8 second rise", v, base + 16'd2);

      // R10 oscillator off
      osc_on = 1'b0;
      evt_in = 1'b0; idle(3 * DIV);
      evt_in = 1'b1; idle(3 * DIV);
      get_cnt(v); chk("R10 no samples", v, base + 16'd2);
      osc_on = 1'b1;
      tick_run = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule